// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch Controller

This controller decides when the system clock leaves one oscillator source and post-divider setting for another. Software writes a requested source code and divider. The controller keeps the current setting in force until the requested oscillator reports that it is stable. It then raises a new-setting-ready flag and a switch flag, and it commits the change unless software has set a hold bit. The committed source and divider are reported as status. The clock multiplexer and its divider are driven from these status fields.

Sources are identified by codes of `SRC_W` bits. A mask parameter marks which codes are PLL outputs. With the default mask, codes 6 and 7 are PLL outputs, and each is fed from a different reference. If both the old and the new code are PLL outputs, the PLL input has to be changed. For that change the controller drops a clock-run output, and it raises the output again only once the PLL reports lock. If lock does not come within a set number of cycles, it raises a sticky fault and falls back to the old setting.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After reset the current source is `RST_SRC` (0) and the divider is `RST_DIV` (0). The request equals the current setting, `osc_ok` is 1, `new_ready`, `sw_flag`, `sw_irq` and `lock_fault` are 0, and `clk_run` is 1.
- R2: While `sw_enable` is 0, a `wr_req` strobe leaves `req_src` and `req_div` unchanged and starts no switch.
- R3: While the requested source differs from the current one and its `osc_ready` bit is 0, `cur_src` and `cur_div` hold and `new_ready` stays 0.
- R4: A request that differs from the current setting makes `new_ready` and `sw_flag` rise on the clock edge after the request is registered. This requires either that the requested source's ready bit is 1 or that only the divider differs. `sw_irq` equals `sw_flag` while the interrupt enable is 1, and it is 0 otherwise. A `clr_flag` strobe clears `sw_flag`.
- R5: With the hold bit 0 and no PLL input change, the edge after `new_ready` rises loads the requested values into `cur_src`/`cur_div`, sets `osc_ok` and clears `new_ready`.
- R6: While the hold bit is 1, a ready switch stays pending: `new_ready` stays 1 and `cur_src` holds. Clearing the hold bit completes the switch on the following edge.
- R7: Writing the current source and divider back as the request abandons a pending switch. On the next edge `new_ready` becomes 0 and `osc_ok` becomes 1, and the current setting does not change. A write of any other setting clears `osc_ok`.
- R8: For a switch between two PLL codes (mask bits set, default codes 6 and 7) with the hold bit 0, `clk_run` goes to 0 on the edge where the switch would otherwise commit. It stays 0 until an edge samples `pll_lock` high. On that edge the new setting is committed and `clk_run` returns to 1.
- R9: If `pll_lock` stays low for `LOCK_TMO` (16) edges while `clk_run` is 0, `lock_fault` sets and stays set until reset. In the same step `clk_run` returns to 1, the current setting is kept, and the request is reset to the current setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_enable | input | 1 | Configuration-level permission for request writes |
| wr_req | input | 1 | Strobe: write `wr_src`/`wr_div` as the request |
| wr_src | input | SRC_W | Requested source code |
| wr_div | input | DIV_W | Requested divider code |
| wr_ctl | input | 1 | Strobe: write hold and interrupt-enable bits |
| ctl_hold | input | 1 | Hold bit value for `wr_ctl` |
| ctl_ie | input | 1 | Interrupt-enable value for `wr_ctl` |
| clr_flag | input | 1 | Strobe: clear the switch flag |
| osc_ready | input | 2**SRC_W | Per-source stable indication |
| pll_lock | input | 1 | PLL lock indication |
| req_src | output | SRC_W | Registered requested source |
| req_div | output | DIV_W | Registered requested divider |
| cur_src | output | SRC_W | Source in force |
| cur_div | output | DIV_W | Divider in force |
| hold_q | output | 1 | Hold bit |
| new_ready | output | 1 | Requested setting ready, switch pending |
| osc_ok | output | 1 | Current setting is the requested one |
| sw_flag | output | 1 | Switch flag |
| sw_irq | output | 1 | Switch interrupt |
| clk_run | output | 1 | Low while the system clock is frozen for a PLL input change |
| lock_fault | output | 1 | Sticky PLL lock timeout fault |

## Verification
The hardest state to reach from the ports is a lock timeout during a PLL input change. It needs the current source to already be one PLL code, the other PLL code requested with its reference ready, the hold bit clear, and `pll_lock` held low for the whole window. Random lock activity almost never keeps lock low that long. A directed sequence therefore first commits a plain switch onto code 6, freezes on a change to 7 and releases it with lock, then requests 6 again with lock held low. A seeded random phase follows, which mixes writes, holds, abandons and ready changes against a cycle model kept in the bench.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic {
    ST_RUN    = 1'b0,
    ST_FREEZE = 1'b1
  } sw_state_e;

  // A source code is a PLL output when its bit in the mask is set.
  function automatic logic is_pll_code(input logic [255:0] mask, input int unsigned code);
    return mask[code];
  endfunction

endpackage

// File: rtl/clksw_req_regs.sv
module clksw_req_regs #(
  parameter int unsigned SRC_W   = 3,
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned RST_SRC = 0,
  parameter int unsigned RST_DIV = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_acc,
  input  logic [SRC_W-1:0] wr_src,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_ctl,
  input  logic             ctl_hold,
  input  logic             ctl_ie,
  input  logic             abort,
  input  logic [SRC_W-1:0] cur_src,
  input  logic [DIV_W-1:0] cur_div,
  output logic [SRC_W-1:0] nsrc_q,
  output logic [DIV_W-1:0] ndiv_q,
  output logic             hold_q,
  output logic             ie_q
);

  logic [SRC_W-1:0] nsrc_d;
  logic [DIV_W-1:0] ndiv_d;
  logic             req_en;

  always_comb begin
    req_en = wr_acc | abort;
    nsrc_d = abort ? cur_src : wr_src;
    ndiv_d = abort ? cur_div : wr_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsrc_q <= SRC_W'(RST_SRC);
      ndiv_q <= DIV_W'(RST_DIV);
    end else if (req_en) begin
      nsrc_q <= nsrc_d;
      ndiv_q <= ndiv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      ie_q   <= 1'b0;
    end else if (wr_ctl) begin
      hold_q <= ctl_hold;
      ie_q   <= ctl_ie;
    end
  end

  // R2: a request changes only on an accepted write or a timeout fallback
  p_req_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_acc && !abort) |=> ($stable(nsrc_q) && $stable(ndiv_q)));

endmodule

// File: rtl/clksw_lock_timer.sv
module clksw_lock_timer #(
  parameter int unsigned LOCK_TMO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int unsigned CNT_W = $clog2(LOCK_TMO + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TMO - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    expired = run && (cnt_q == LAST);
    if (!run || expired) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: the wait window never runs past its limit
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int unsigned SRC_W    = 3,
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned RST_SRC  = 0,
  parameter int unsigned RST_DIV  = 0,
  parameter logic [255:0] PLL_MASK = 256'hC0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_acc,
  input  logic [SRC_W-1:0]     wr_src,
  input  logic [DIV_W-1:0]     wr_div,
  input  logic [SRC_W-1:0]     nsrc,
  input  logic [DIV_W-1:0]     ndiv,
  input  logic                 hold,
  input  logic                 clr_flag,
  input  logic [(1<<SRC_W)-1:0] osc_ready,
  input  logic                 pll_lock,
  input  logic                 tmo_hit,
  output logic [SRC_W-1:0]     cur_src,
  output logic [DIV_W-1:0]     cur_div,
  output logic                 nrdy_q,
  output logic                 ordy_q,
  output logic                 swif_q,
  output logic                 fault_q,
  output logic                 freeze,
  output logic                 abort
);

  sw_state_e        st_q, st_d;
  logic [SRC_W-1:0] cur_d;
  logic [DIV_W-1:0] div_d;
  logic             nrdy_d, ordy_d, swif_d, fault_d;
  logic             pending, tgt_ok, pll_in_chg, set_flag, commit;

  always_comb begin
    pending    = (nsrc != cur_src) || (ndiv != cur_div);
    tgt_ok     = (nsrc == cur_src) || osc_ready[nsrc];
    pll_in_chg = is_pll_code(PLL_MASK, int'(nsrc)) &&
                 is_pll_code(PLL_MASK, int'(cur_src)) && (nsrc != cur_src);
  end

  always_comb begin
    st_d     = st_q;
    nrdy_d   = nrdy_q;
    ordy_d   = ordy_q;
    fault_d  = fault_q;
    set_flag = 1'b0;
    commit   = 1'b0;
    abort    = 1'b0;
    case (st_q)
      ST_FREEZE: begin
        if (pll_lock) begin
          commit = 1'b1;
          st_d   = ST_RUN;
        end else if (tmo_hit) begin
          fault_d = 1'b1;
          nrdy_d  = 1'b0;
          ordy_d  = 1'b1;
          abort   = 1'b1;
          st_d    = ST_RUN;
        end
      end
      default: begin
        if (wr_acc) begin
          nrdy_d = 1'b0;
          ordy_d = (wr_src == cur_src) && (wr_div == cur_div);
        end else if (nrdy_q) begin
          if (!hold) begin
            if (pll_in_chg) st_d = ST_FREEZE;
            else            commit = 1'b1;
          end
        end else if (pending && tgt_ok) begin
          nrdy_d   = 1'b1;
          set_flag = 1'b1;
        end
      end
    endcase
    if (commit) begin
      nrdy_d = 1'b0;
      ordy_d = 1'b1;
    end
    cur_d  = commit ? nsrc : cur_src;
    div_d  = commit ? ndiv : cur_div;
    swif_d = set_flag ? 1'b1 : (clr_flag ? 1'b0 : swif_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      cur_src <= SRC_W'(RST_SRC);
      cur_div <= DIV_W'(RST_DIV);
      nrdy_q  <= 1'b0;
      ordy_q  <= 1'b1;
      swif_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_src <= cur_d;
      cur_div <= div_d;
      nrdy_q  <= nrdy_d;
      ordy_q  <= ordy_d;
      swif_q  <= swif_d;
      fault_q <= fault_d;
    end
  end

  assign freeze = (st_q == ST_FREEZE);

  // R3: without readiness the current setting never moves
  p_wait_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nrdy_q && !freeze) |=> ($stable(cur_src) && $stable(cur_div)));

  // R4: readiness always arrives together with the flag
  p_flag_with_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nrdy_q) |-> swif_q);

  // R5: an unheld, ordinary ready switch commits on the next edge
  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && nrdy_q && !hold && !wr_acc && !pll_in_chg) |=> (!nrdy_q && ordy_q));

  // R6: a held switch stays pending on the old setting
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && nrdy_q && hold && !wr_acc) |=> (nrdy_q && $stable(cur_src)));

  // R8: the frozen clock stays stopped until lock or timeout
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !pll_lock && !tmo_hit) |=> (freeze && $stable(cur_src)));

  // R9: the lock fault is sticky
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |=> fault_q);

endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl #(
  parameter int unsigned  SRC_W    = 3,
  parameter int unsigned  DIV_W    = 4,
  parameter int unsigned  RST_SRC  = 0,
  parameter int unsigned  RST_DIV  = 0,
  parameter int unsigned  LOCK_TMO = 16,
  parameter logic [255:0] PLL_MASK = 256'hC0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sw_enable,
  input  logic                  wr_req,
  input  logic [SRC_W-1:0]      wr_src,
  input  logic [DIV_W-1:0]      wr_div,
  input  logic                  wr_ctl,
  input  logic                  ctl_hold,
  input  logic                  ctl_ie,
  input  logic                  clr_flag,
  input  logic [(1<<SRC_W)-1:0] osc_ready,
  input  logic                  pll_lock,
  output logic [SRC_W-1:0]      req_src,
  output logic [DIV_W-1:0]      req_div,
  output logic [SRC_W-1:0]      cur_src,
  output logic [DIV_W-1:0]      cur_div,
  output logic                  hold_q,
  output logic                  new_ready,
  output logic                  osc_ok,
  output logic                  sw_flag,
  output logic                  sw_irq,
  output logic                  clk_run,
  output logic                  lock_fault
);

  logic wr_acc, ie_q, freeze, abort, tmo_hit, lock_wait;

  assign wr_acc    = wr_req && sw_enable && !freeze;
  assign lock_wait = freeze && !pll_lock;
  assign clk_run   = !freeze;
  assign sw_irq    = sw_flag && ie_q;

  clksw_req_regs #(
    .SRC_W(SRC_W), .DIV_W(DIV_W), .RST_SRC(RST_SRC), .RST_DIV(RST_DIV)
  ) u_req (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_src(wr_src), .wr_div(wr_div),
    .wr_ctl(wr_ctl), .ctl_hold(ctl_hold), .ctl_ie(ctl_ie), .abort(abort),
    .cur_src(cur_src), .cur_div(cur_div), .nsrc_q(req_src), .ndiv_q(req_div),
    .hold_q(hold_q), .ie_q(ie_q)
  );

  clksw_lock_timer #(.LOCK_TMO(LOCK_TMO)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(lock_wait), .expired(tmo_hit)
  );

  clksw_seq #(
    .SRC_W(SRC_W), .DIV_W(DIV_W), .RST_SRC(RST_SRC), .RST_DIV(RST_DIV),
    .PLL_MASK(PLL_MASK)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .wr_src(wr_src), .wr_div(wr_div),
    .nsrc(req_src), .ndiv(req_div), .hold(hold_q), .clr_flag(clr_flag),
    .osc_ready(osc_ready), .pll_lock(pll_lock), .tmo_hit(tmo_hit),
    .cur_src(cur_src), .cur_div(cur_div), .nrdy_q(new_ready), .ordy_q(osc_ok),
    .swif_q(sw_flag), .fault_q(lock_fault), .freeze(freeze), .abort(abort)
  );

  // R2: with writes disabled the request does not move
  p_locked_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !sw_enable && !freeze) |=> ($stable(req_src) && $stable(req_div)));

endmodule

// File: tb/clk_switch_ctrl_test.sv
module clk_switch_ctrl_test;

  localparam int SW = 3;
  localparam int DW = 4;
  localparam int NS = 1 << SW;
  localparam int TMO = 16;
  localparam logic [NS-1:0] PMASK = 8'hC0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_enable = 1'b1, wr_req = 1'b0, wr_ctl = 1'b0, ctl_hold = 1'b0, ctl_ie = 1'b0;
  logic clr_flag = 1'b0, pll_lock = 1'b0;
  logic [SW-1:0] wr_src = '0;
  logic [DW-1:0] wr_div = '0;
  logic [NS-1:0] osc_ready = 8'h01;
  logic [SW-1:0] req_src, cur_src;
  logic [DW-1:0] req_div, cur_div;
  logic hold_q, new_ready, osc_ok, sw_flag, sw_irq, clk_run, lock_fault;

  int n_chk = 0, n_fail = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_switch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sw_enable(sw_enable), .wr_req(wr_req), .wr_src(wr_src),
    .wr_div(wr_div), .wr_ctl(wr_ctl), .ctl_hold(ctl_hold), .ctl_ie(ctl_ie),
    .clr_flag(clr_flag), .osc_ready(osc_ready), .pll_lock(pll_lock),
    .req_src(req_src), .req_div(req_div), .cur_src(cur_src), .cur_div(cur_div),
    .hold_q(hold_q), .new_ready(new_ready), .osc_ok(osc_ok), .sw_flag(sw_flag),
    .sw_irq(sw_irq), .clk_run(clk_run), .lock_fault(lock_fault)
  );

  // Reference model built from the requirements
  logic [SW-1:0] m_cur, m_nsrc;
  logic [DW-1:0] m_div, m_ndiv;
  logic m_hold, m_ie, m_nrdy, m_ordy, m_swif, m_fault, m_frz;
  int   m_cnt;

  function automatic bit pll_code(input logic [SW-1:0] c);
    return PMASK[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = '0; m_div = '0; m_nsrc = '0; m_ndiv = '0; m_hold = 0; m_ie = 0;
      m_nrdy = 0; m_ordy = 1; m_swif = 0; m_fault = 0; m_frz = 0; m_cnt = 0;
    end else begin
      automatic bit old_hold = m_hold;
      automatic bit setf = 0;
      automatic bit pend = (m_nsrc != m_cur) || (m_ndiv != m_div);
      automatic bit rdy  = (m_nsrc == m_cur) || osc_ready[m_nsrc];
      automatic bit pch  = pll_code(m_nsrc) && pll_code(m_cur) && (m_nsrc != m_cur);
      if (wr_ctl) begin m_hold = ctl_hold; m_ie = ctl_ie; end
      if (m_frz) begin
        if (pll_lock) begin
          m_cur = m_nsrc; m_div = m_ndiv; m_nrdy = 0; m_ordy = 1; m_frz = 0; m_cnt = 0;
        end else if (m_cnt == TMO - 1) begin
          m_fault = 1; m_frz = 0; m_nsrc = m_cur; m_ndiv = m_div;
          m_nrdy = 0; m_ordy = 1; m_cnt = 0;
        end else m_cnt++;
      end else if (wr_req && sw_enable) begin
        m_nrdy = 0;
        m_ordy = (wr_src == m_cur) && (wr_div == m_div);
        m_nsrc = wr_src; m_ndiv = wr_div;
      end else if (m_nrdy) begin
        if (!old_hold) begin
          if (pch) begin m_frz = 1; m_cnt = 0; end
          else begin m_cur = m_nsrc; m_div = m_ndiv; m_nrdy = 0; m_ordy = 1; end
        end
      end else if (pend && rdy) begin
        m_nrdy = 1; setf = 1;
      end
      if (setf) m_swif = 1;
      else if (clr_flag) m_swif = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d @%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R5", "model cur_src", cur_src, m_cur);
      chk("R5", "model cur_div", cur_div, m_div);
      chk("R4", "model new_ready", new_ready, m_nrdy);
      chk("R7", "model osc_ok", osc_ok, m_ordy);
      chk("R4", "model sw_flag", sw_flag, m_swif);
      chk("R4", "model sw_irq", sw_irq, m_swif && m_ie);
      chk("R8", "model clk_run", clk_run, !m_frz);
      chk("R9", "model lock_fault", lock_fault, m_fault);
      chk("R2", "model req_src", req_src, m_nsrc);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic do_req(input int s, input int d);
    wr_req = 1; wr_src = SW'(s); wr_div = DW'(d);
    tick();
    wr_req = 0;
  endtask

  task automatic do_ctl(input bit h, input bit ie);
    wr_ctl = 1; ctl_hold = h; ctl_ie = ie;
    tick();
    wr_ctl = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1", "cur_src", cur_src, 0);
    chk("R1", "osc_ok", osc_ok, 1);
    chk("R1", "new_ready", new_ready, 0);
    chk("R1", "clk_run", clk_run, 1);
    chk("R1", "lock_fault", lock_fault, 0);
    model_on = 1;

    // R3 wait for an unready source
    do_req(2, 0);
    repeat (5) tick();
    chk("R3", "cur_src while waiting", cur_src, 0);
    chk("R3", "new_ready while waiting", new_ready, 0);
    osc_ready[2] = 1;
    tick();
    chk("R4", "new_ready on ready", new_ready, 1);
    chk("R4", "sw_irq with enable 0", sw_irq, 0);
    tick();
    chk("R5", "cur_src committed", cur_src, 2);
    chk("R5", "new_ready cleared", new_ready, 0);
    do_ctl(0, 1);
    chk("R4", "sw_irq with enable 1", sw_irq, 1);
    clr_flag = 1; tick(); clr_flag = 0;
    chk("R4", "sw_flag cleared", sw_flag, 0);

    // R6 hold
    do_ctl(1, 1);
    osc_ready[3] = 1;
    do_req(3, 0);
    repeat (6) tick();
    chk("R6", "cur_src held", cur_src, 2);
    chk("R6", "new_ready held", new_ready, 1);
    do_ctl(0, 1);
    tick();
    chk("R6", "cur_src after release", cur_src, 3);

    // R7 abandon
    do_ctl(1, 0);
    osc_ready[1] = 1;
    do_req(1, 0);
    tick();
    chk("R7", "new_ready before abandon", new_ready, 1);
    do_req(3, 0);
    chk("R7", "new_ready abandoned", new_ready, 0);
    chk("R7", "osc_ok after abandon", osc_ok, 1);
    repeat (3) tick();
    chk("R7", "cur_src after abandon", cur_src, 3);
    do_ctl(0, 0);

    // R4 divider-only change with every ready low
    osc_ready = '0;
    do_req(3, 5);
    chk("R7", "osc_ok cleared by new request", osc_ok, 0);
    tick();
    chk("R4", "divider-only ready", new_ready, 1);
    tick();
    chk("R5", "cur_div committed", cur_div, 5);

    // R2 write lockout
    sw_enable = 0;
    do_req(4, 1);
    chk("R2", "req_src locked", req_src, 3);
    chk("R2", "req_div locked", req_div, 5);
    repeat (3) tick();
    chk("R2", "cur_src unchanged", cur_src, 3);
    sw_enable = 1;

    // R8 PLL input change
    osc_ready = 8'hC8;
    do_req(6, 5); tick(); tick();
    chk("R8", "onto PLL code 6", cur_src, 6);
    do_req(7, 5); tick(); tick();
    chk("R8", "clk_run frozen", clk_run, 0);
    chk("R8", "cur_src during freeze", cur_src, 6);
    repeat (4) tick();
    chk("R8", "still frozen", clk_run, 0);
    pll_lock = 1; tick(); pll_lock = 0;
    chk("R8", "cur_src after lock", cur_src, 7);
    chk("R8", "clk_run after lock", clk_run, 1);

    // R9 lock timeout
    do_req(6, 5); tick(); tick();
    chk("R9", "frozen for timeout", clk_run, 0);
    repeat (TMO - 1) tick();
    chk("R9", "no fault before limit", lock_fault, 0);
    tick();
    chk("R9", "fault at limit", lock_fault, 1);
    chk("R9", "clk_run restored", clk_run, 1);
    chk("R9", "cur_src kept", cur_src, 7);
    chk("R9", "request reset", req_src, 7);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      sw_enable = ($urandom % 16) != 0;
      wr_req    = ($urandom % 6) == 0;
      wr_src    = SW'($urandom);
      wr_div    = DW'($urandom % 3);
      wr_ctl    = ($urandom % 12) == 0;
      ctl_hold  = ($urandom % 3) == 0;
      ctl_ie    = ($urandom % 2) == 0;
      clr_flag  = ($urandom % 10) == 0;
      pll_lock  = ($urandom % 4) == 0;
      if (($urandom % 8) == 0) osc_ready[$urandom % NS] ^= 1'b1;
      tick();
    end
    wr_req = 0; wr_ctl = 0; clr_flag = 0;
    tick();
    finish_run();
  end

endmodule